// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between an internal request bus and an external asynchronous static RAM of one mega-word by sixteen bits. It accepts one word-sized read or write at a time over a valid/ready handshake and turns it into a correctly timed sequence on the memory pins. Each read or write can enable either byte lane or both. The chip select has two polarities: one select is active low and one is active high. Every phase of a cycle lasts a whole number of clocks, and each count is computed from a nanosecond minimum and the clock period parameter, rounded up.

A write opens with a short setup phase. In that phase the selects and byte lanes go active and the write data is driven. The write-enable pulse follows, and a recovery phase after it keeps the data driven past the rising edge of write enable. A read holds select, output enable and the byte lanes for the full access time. It then returns the masked word on a one-clock strobe and keeps the bus quiet for a turnaround period, so the memory's drivers are off before this block can drive the bus again.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, with no request, the block holds ready high, chip-select-low high, chip-select-high low, write enable, output enable and both byte lanes inactive (high), and the data output enable low.
- R2: A request is taken on the clock edge where valid and ready are both high. Ready then stays low for 14 clocks for a write and 19 clocks for a read, with the default parameters. A valid held high while ready is low has no effect on the pins.
- R3: A write drives both selects active and the byte lanes for 2 clocks with write enable high, then 10 clocks with write enable low, then 2 clocks with write enable high. Request enable bit 0 drives the low-byte lane pin low and bit 1 drives the high-byte lane pin low.
- R4: The output enable pin stays high for the whole of a write. The data output enable is high only while the output enable pin is high.
- R5: A read holds both selects, output enable and the requested byte lanes active for 14 clocks. Write enable stays high and the data bus is not driven.
- R6: The read strobe is high for exactly one clock, the clock after the access phase ends. It carries the sampled word, with each disabled lane returned as zero.
- R7: After a read, the block keeps every pin deselected for 5 clocks. Only after that can the next cycle drive the data bus.
- R8: Address, byte lanes and write data are captured when the request is taken and stay constant until the cycle ends.
- R9: Every phase length equals the ceiling of its nanosecond minimum divided by the clock period, with a floor of one clock. The setup phase covers the 5 ns by which the 45 ns byte-lane minimum exceeds the 40 ns pulse minimum. The recovery phase makes up the rest of the 55 ns cycle, and the read access takes the larger of the 55 ns access and cycle times.
- R10: A write with both enables clear runs the full write timing but keeps both lanes high, so memory is unchanged. A read with both enables clear returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 20 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bhe_n | output | 1 | High byte lane enable, active low |
| mem_ble_n | output | 1 | Low byte lane enable, active low |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Count clocks from the edge that takes a request. A write's pins change after edges 0, 2, 12 and 14. A read's pins change after edges 0 and 14, its strobe and data appear after edge 14, and ready returns after edge 19. The bench drives on the falling edge and keeps a behavioural model that counts the clocks since acceptance. At every falling edge it compares all pins, ready and the strobe against what that count predicts, so a phase that is one clock long or short shows up on the cycle where it occurs. Read data comes from a pin-level memory model in the bench, and disabled lanes return garbage so that the masking is tested.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int T_PWE_NS      = 40,
  parameter int T_BW_NS       = 45,
  parameter int T_WC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_RC_NS       = 55,
  parameter int T_TURN_NS     = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_bhe_n,
  output logic          mem_ble_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 1 : (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  localparam int BW       = DW / 2;
  localparam int SET_CYC  = cyc(T_BW_NS - T_PWE_NS);
  localparam int WP_CYC   = cyc(T_PWE_NS);
  localparam int REC_RAW  = cyc(T_WC_NS) - SET_CYC - WP_CYC;
  localparam int REC_CYC  = (REC_RAW < 1) ? 1 : REC_RAW;
  localparam int RD_CYC   = (cyc(T_AA_NS) > cyc(T_RC_NS)) ? cyc(T_AA_NS) : cyc(T_RC_NS);
  localparam int TURN_CYC = cyc(T_TURN_NS);
  localparam int CW       = $clog2(SET_CYC + WP_CYC + REC_CYC + RD_CYC + TURN_CYC + 2);

  localparam logic [CW-1:0] SET_LD  = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD  = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WREC, S_RD, S_TURN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_bhe_n  <= 1'b1;
      mem_ble_n  <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
          mem_ce1_n  <= 1'b0;
          mem_ce2    <= 1'b1;
          mem_ble_n  <= ~req_be[0];
          mem_bhe_n  <= ~req_be[1];
          if (req_write) begin
            state     <= S_WSET;
            cnt       <= SET_LD;
            mem_dq_oe <= 1'b1;
          end else begin
            state    <= S_RD;
            cnt      <= RD_LD;
            mem_oe_n <= 1'b0;
          end
        end
        S_WSET: if (last) begin
          state    <= S_WPUL;
          cnt      <= WP_LD;
          mem_we_n <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (last) begin
          state    <= S_WREC;
          cnt      <= REC_LD;
          mem_we_n <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) begin
          state     <= S_IDLE;
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_bhe_n <= 1'b1;
          mem_ble_n <= 1'b1;
          mem_dq_oe <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_RD: if (last) begin
          state     <= S_TURN;
          cnt       <= TURN_LD;
          rsp_valid <= 1'b1;
          rsp_rdata <= {mem_bhe_n ? {BW{1'b0}} : mem_dq_in[DW-1:BW],
                        mem_ble_n ? {BW{1'b0}} : mem_dq_in[BW-1:0]};
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_oe_n  <= 1'b1;
          mem_bhe_n <= 1'b1;
          mem_ble_n <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] since_oe, we_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_oe <= '1;
      we_low   <= '0;
    end else begin
      since_oe <= !mem_oe_n ? '0 : (since_oe == '1 ? since_oe : since_oe + 1'b1);
      we_low   <= !mem_we_n ? we_low + 1'b1 : '0;
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low >= CW'(WP_CYC))); // R3
  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n && !mem_ce1_n && mem_ce2)); // R4
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= CW'(TURN_CYC))); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> ($stable(mem_addr) && $stable(mem_bhe_n) && $stable(mem_ble_n))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R8
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce1_n && mem_ce2)); // R5

endmodule

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;
  localparam int SET = 2, WP = 10, REC = 2, RD = 14, TURN = 5;
  localparam int WLEN = SET + WP + REC, RLEN = RD + TURN;

  typedef struct { bit wr; logic [19:0] a; logic [15:0] d; logic [1:0] be; } req_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_bhe_n, mem_ble_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in = 16'hDEAD;
  logic [19:0] mem_addr;

  always #2 clk = ~clk;

  async_sram_ctrl u_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bhe_n(mem_bhe_n), .mem_ble_n(mem_ble_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // pin-level memory: disabled lanes return garbage
  logic [15:0] ram [int];
  logic [15:0] ref_mem [int];
  logic prev_we = 1'b1;

  function automatic logic [15:0] rd_ram(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [15:0] w;
    if (!prev_we && mem_we_n && !mem_ce1_n && mem_ce2 && mem_dq_oe) begin
      w = rd_ram(int'(mem_addr));
      if (!mem_ble_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_bhe_n) w[15:8] = mem_dq_out[15:8];
      ram[int'(mem_addr)] = w;
    end
    prev_we = mem_we_n;
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
      w = rd_ram(int'(mem_addr));
      mem_dq_in <= {mem_bhe_n ? 8'hA5 : w[15:8], mem_ble_n ? 8'hA5 : w[7:0]};
    end else mem_dq_in <= 16'hDEAD;
  end

  // reference model, compared every clock
  req_t q[$];
  req_t cur;
  bit busy = 0, acc_pend = 0;
  int k = 0, compared = 0, mismatched = 0;
  bit cyc_bad;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      cyc_bad = 1;
      $display("FAIL %s %s at t=%0t k=%0d: actual %h expected %h", tag, what, $time, k, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_sel, e_we, e_oe, e_dq, e_rv, e_bh, e_bl;
    logic [15:0] w, e_rd;
    string tg;
    if (acc_pend) begin
      cur = q.pop_front(); busy = 1; k = 1;
      if (cur.wr) begin
        w = rd_ref(int'(cur.a));
        if (cur.be[0]) w[7:0]  = cur.d[7:0];
        if (cur.be[1]) w[15:8] = cur.d[15:8];
        ref_mem[int'(cur.a)] = w;
      end
    end else if (busy) begin
      k++;
      if (k > (cur.wr ? WLEN : RLEN)) busy = 0;
    end
    e_sel = 0; e_we = 1; e_oe = 1; e_dq = 0; e_rv = 0; e_bh = 1; e_bl = 1; e_rd = '0;
    tg = rst_n ? "R2" : "R1";
    if (busy && cur.wr) begin
      e_sel = 1; e_dq = 1; e_bh = !cur.be[1]; e_bl = !cur.be[0];
      e_we = !(k > SET && k <= SET + WP);
      tg = "R3";
    end else if (busy && k <= RD) begin
      e_sel = 1; e_oe = 0; e_bh = !cur.be[1]; e_bl = !cur.be[0];
      tg = "R5";
    end else if (busy) begin
      tg = "R7";
      if (k == RD + 1) begin
        e_rv = 1;
        w = rd_ref(int'(cur.a));
        e_rd = {cur.be[1] ? w[15:8] : 8'h00, cur.be[0] ? w[7:0] : 8'h00};
      end
    end
    cyc_bad = 0;
    chk("R2", "req_ready", req_ready, !busy);
    chk(tg, "mem_ce1_n", mem_ce1_n, !e_sel);
    chk(tg, "mem_ce2", mem_ce2, e_sel);
    chk(busy && cur.wr ? "R9" : tg, "mem_we_n", mem_we_n, e_we);
    chk(busy && cur.wr ? "R4" : tg, "mem_oe_n", mem_oe_n, e_oe);
    chk(busy && !cur.wr ? "R7" : tg, "mem_dq_oe", mem_dq_oe, e_dq);
    chk(busy && cur.be == 2'b00 ? "R10" : tg, "mem_bhe_n", mem_bhe_n, e_bh);
    chk(busy && cur.be == 2'b00 ? "R10" : tg, "mem_ble_n", mem_ble_n, e_bl);
    chk("R6", "rsp_valid", rsp_valid, e_rv);
    if (e_sel) chk("R8", "mem_addr", mem_addr, cur.a);
    if (e_dq)  chk("R8", "mem_dq_out", mem_dq_out, cur.d);
    if (e_rv)  chk(cur.be == 2'b00 ? "R10" : "R6", "rsp_rdata", rsp_rdata, e_rd);
    compared++;
    if (cyc_bad) mismatched++;
    acc_pend = 0;
    if (rst_n && q.size() > 0) begin
      req_valid = 1; req_write = q[0].wr; req_addr = q[0].a; req_wdata = q[0].d; req_be = q[0].be;
      acc_pend = !busy;
    end else begin
      req_valid = 0;
    end
  end

  task automatic push(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    req_t r;
    r.wr = wr; r.a = a; r.d = d; r.be = be;
    q.push_back(r);
  endtask

  task automatic drain;
    int n = 0;
    while ((q.size() > 0 || busy || acc_pend) && n < 20000) begin
      @(posedge clk); n++;
    end
    if (n >= 20000) begin
      mismatched++;
      $display("FAIL R2 watchdog expired: actual busy expected idle");
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);             // R1: idle pins compared in reset
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    push(1, 20'h00010, 16'h1234, 2'b11);   // R3 full write
    push(0, 20'h00010, 16'h0000, 2'b11);   // R5/R6 full read after write
    push(0, 20'h00010, 16'h0000, 2'b01);   // R6 low lane only
    push(0, 20'h00010, 16'h0000, 2'b10);   // R6 high lane only
    push(1, 20'h00010, 16'hAB99, 2'b01);   // R7 write after read
    push(1, 20'h00010, 16'h77FF, 2'b10);
    push(0, 20'h00010, 16'h0000, 2'b11);   // expect 7799
    push(1, 20'h00010, 16'hFFFF, 2'b00);   // R10 no lane written
    push(0, 20'h00010, 16'h0000, 2'b11);   // still 7799
    push(0, 20'h00010, 16'h0000, 2'b00);   // R10 read returns zero
    drain();
    repeat (7) @(posedge clk);             // idle gap
    push(1, 20'hFFFFF, 16'hC3C3, 2'b11);
    push(1, 20'h00000, 16'h5A5A, 2'b11);
    push(0, 20'hFFFFF, 16'h0000, 2'b11);
    push(0, 20'h00000, 16'h0000, 2'b11);
    push(0, 20'h00ABC, 16'h0000, 2'b11);   // unwritten word
    push(1, 20'h00ABC, 16'h0F0F, 2'b01);
    push(0, 20'h00ABC, 16'h0000, 2'b11);
    drain();
    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule